// File: doc/BRIEF.md
# Exception Control Coprocessor

This block is the system-control coprocessor of a small 32-bit load-store processor. It keeps three architectural registers: a Status word (interrupt enable, user/kernel mode, per-line interrupt mask), a Cause word (exception code and live pending-interrupt bits) and a saved resume address (EPC). When the pipeline raises a synchronous trap, or when an enabled and unmasked device interrupt is pending while the core runs in user mode, the block records the reason and the faulting PC, drops into kernel mode and tells the fetch logic to jump to the fixed handler vector.

Software reads and writes the three registers through a single-cycle register-access port addressed by coprocessor register number. An exception-return request redirects fetch to the saved address and puts the core back into user mode. A handler that wants to skip the trapping instruction adds 4 to EPC before it returns.

Top module: `sysctl_cop`

## Requirements
- R1: Synchronous reset clears Status (kernel mode, interrupt enable 0, mask 0), Cause and EPC to zero, drives `kernel_mode` to 1, `redirect_valid` to 0, `redirect_pc` and `acc_rdata` to 0.
- R2: Register number 12 selects Status, 13 selects Cause and 14 selects EPC. `acc_rdata` shows, one cycle after the address, the value that register held before that edge; every other number reads 0, and writes to other numbers change nothing.
- R3: Status bit 0 is the global interrupt enable (1 = enabled), bit 1 is the mode (1 = user, 0 = kernel), bits 15:8 are the interrupt mask; these bits are writable and all other Status bits read 0. `kernel_mode` equals the inverse of Status bit 1.
- R4: Cause bits 6:2 hold the 5-bit exception code and are software-writable; Cause bits 15:10 are read-only pending bits equal to `irq_lines` sampled at the previous edge (line i in bit 10+i); all other Cause bits read 0.
- R5: A trap request makes, one cycle later, `redirect_valid` = 1 with `redirect_pc` = 0x80000080, EPC = `pc_in`, Cause code = `trap_code` (12 for overflow) and kernel mode.
- R6: An interrupt is taken when Status bit 0 is 1, the core is in user mode, and some pending bit 10+i has Status mask bit 10+i set; one cycle later the redirect to 0x80000080 is shown, EPC = `pc_in`, Cause code = 0 and kernel mode.
- R7: A pending interrupt is not taken when the global enable is 0, when the core is in kernel mode, or when its mask bit is 0.
- R8: A trap request and a takeable interrupt in the same cycle record the trap's code; the pending bits still follow the lines.
- R9: An exception-return request with no exception in the same cycle redirects to the EPC value held before that edge and sets user mode, one cycle later.
- R10: When an exception coincides with a register write, the exception's updates (EPC, code, mode bit) win over the written values; an exception also wins over a simultaneous exception return.
- R11: `redirect_valid` is 0 in the cycle after any edge with no trap, no taken interrupt and no exception return; `redirect_pc` then holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trap_req | input | 1 | Synchronous trap from the instruction stream |
| trap_code | input | 5 | Exception code of the trap |
| pc_in | input | 32 | PC of the instruction in the exception stage |
| irq_lines | input | 6 | Device interrupt lines |
| eret_req | input | 1 | Exception-return request |
| acc_wr | input | 1 | Register write strobe |
| acc_addr | input | 5 | Coprocessor register number |
| acc_wdata | input | 32 | Register write data |
| acc_rdata | output | 32 | Registered read data |
| redirect_valid | output | 1 | Fetch redirect request |
| redirect_pc | output | 32 | Fetch redirect target |
| kernel_mode | output | 1 | 1 while in kernel mode |

## Verification
Traps, exception returns and register reads are due one edge after the request, while an interrupt line needs two edges: one to land in the pending bits and one more for the redirect. The bench changes inputs on the falling edge, advances a reference model by exactly one rising edge, and compares every output at the following falling edge, so each result is checked in the cycle it is due. Directed sequences cover masking, mode and enable gating, and same-cycle collisions before a seeded random run.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int CODE_W  = 5;
  localparam int RADDR_W = 5;

  localparam logic [RADDR_W-1:0] REG_STATUS = 5'd12;
  localparam logic [RADDR_W-1:0] REG_CAUSE  = 5'd13;
  localparam logic [RADDR_W-1:0] REG_EPC    = 5'd14;

  localparam logic [CODE_W-1:0] CODE_IRQ = 5'd0;
  localparam logic [CODE_W-1:0] CODE_OVF = 5'd12;

  // Status field positions
  localparam int ST_IE      = 0;
  localparam int ST_UM      = 1;
  localparam int ST_MASK_LO = 8;
  localparam int ST_MASK_HI = 15;

  // Cause field positions
  localparam int CA_CODE_LO = 2;
  localparam int CA_CODE_HI = CA_CODE_LO + CODE_W - 1;
  localparam int CA_PEND_LO = 10;
  localparam int CA_PEND_HI = 15;

  typedef enum logic [1:0] {
    EV_NONE = 2'd0,
    EV_TRAP = 2'd1,
    EV_IRQ  = 2'd2,
    EV_ERET = 2'd3
  } event_e;
endpackage

// File: rtl/sysctl_arb.sv
module sysctl_arb
  import sysctl_pkg::*;
#(
  parameter int NIRQ = 6
) (
  input  logic            trap_req,
  input  logic            eret_req,
  input  logic            ie,
  input  logic            um,
  input  logic [NIRQ-1:0] pend,
  input  logic [NIRQ-1:0] en_mask,
  output event_e          ev
);
  logic irq_ok;

  assign irq_ok = ie && um && ((pend & en_mask) != '0);

  // Fixed priority: trap, then interrupt, then exception return.
  always_comb begin
    if (trap_req)      ev = EV_TRAP;
    else if (irq_ok)   ev = EV_IRQ;
    else if (eret_req) ev = EV_ERET;
    else               ev = EV_NONE;
  end
endmodule

// File: rtl/sysctl_status.sv
module sysctl_status
  import sysctl_pkg::*;
#(
  parameter int MASK_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wd_ie,
  input  logic              wd_um,
  input  logic [MASK_W-1:0] wd_mask,
  input  event_e            ev,
  output logic              ie,
  output logic              um,
  output logic [MASK_W-1:0] mask
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ie   <= 1'b0;
      um   <= 1'b0;
      mask <= '0;
    end else begin
      if (wr_en) begin
        ie   <= wd_ie;
        mask <= wd_mask;
        um   <= wd_um;
      end
      // Events own the mode bit over a concurrent write.
      case (ev)
        EV_TRAP, EV_IRQ: um <= 1'b0;
        EV_ERET:         um <= 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/sysctl_cause.sv
module sysctl_cause
  import sysctl_pkg::*;
#(
  parameter int NIRQ = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CODE_W-1:0] wd_code,
  input  logic [CODE_W-1:0] trap_code,
  input  logic [NIRQ-1:0]   irq_lines,
  input  event_e            ev,
  output logic [NIRQ-1:0]   pend,
  output logic [CODE_W-1:0] code
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= '0;
      code <= '0;
    end else begin
      pend <= irq_lines;
      case (ev)
        EV_TRAP: code <= trap_code;
        EV_IRQ:  code <= CODE_IRQ;
        default: if (wr_en) code <= wd_code;
      endcase
    end
  end
endmodule

// File: rtl/sysctl_epc.sv
module sysctl_epc #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [XLEN-1:0] wd,
  input  logic            capture,
  input  logic [XLEN-1:0] pc_in,
  output logic [XLEN-1:0] epc
);
  always_ff @(posedge clk) begin
    if (rst)          epc <= '0;
    else if (capture) epc <= pc_in;
    else if (wr_en)   epc <= wd;
  end
endmodule

// File: rtl/sysctl_cop.sv
module sysctl_cop
  import sysctl_pkg::*;
#(
  parameter int              XLEN        = 32,
  parameter logic [XLEN-1:0] VECTOR_ADDR = 32'h8000_0080
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               trap_req,
  input  logic [CODE_W-1:0]  trap_code,
  input  logic [XLEN-1:0]    pc_in,
  input  logic [CA_PEND_HI-CA_PEND_LO:0] irq_lines,
  input  logic               eret_req,
  input  logic               acc_wr,
  input  logic [RADDR_W-1:0] acc_addr,
  input  logic [XLEN-1:0]    acc_wdata,
  output logic [XLEN-1:0]    acc_rdata,
  output logic               redirect_valid,
  output logic [XLEN-1:0]    redirect_pc,
  output logic               kernel_mode
);
  localparam int MASK_W = ST_MASK_HI - ST_MASK_LO + 1;
  localparam int NIRQ   = CA_PEND_HI - CA_PEND_LO + 1;
  localparam int IRQ_MASK_LO = CA_PEND_LO - ST_MASK_LO;

  logic              st_ie;
  logic              st_um;
  logic [MASK_W-1:0] st_mask;
  logic [NIRQ-1:0]   ca_pend;
  logic [CODE_W-1:0] ca_code;
  logic [XLEN-1:0]   epc_q;
  logic [NIRQ-1:0]   irq_mask;
  event_e            ev;
  logic              wr_st, wr_ca, wr_epc, take_exc;
  logic [XLEN-1:0]   rd_status, rd_cause, rd_mux;

  assign wr_st    = acc_wr && (acc_addr == REG_STATUS);
  assign wr_ca    = acc_wr && (acc_addr == REG_CAUSE);
  assign wr_epc   = acc_wr && (acc_addr == REG_EPC);
  assign irq_mask = st_mask[MASK_W-1:IRQ_MASK_LO];
  assign take_exc = (ev == EV_TRAP) || (ev == EV_IRQ);

  sysctl_arb #(.NIRQ(NIRQ)) u_arb (
    .trap_req (trap_req),
    .eret_req (eret_req),
    .ie       (st_ie),
    .um       (st_um),
    .pend     (ca_pend),
    .en_mask  (irq_mask),
    .ev       (ev)
  );

  sysctl_status #(.MASK_W(MASK_W)) u_status (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_st),
    .wd_ie   (acc_wdata[ST_IE]),
    .wd_um   (acc_wdata[ST_UM]),
    .wd_mask (acc_wdata[ST_MASK_HI:ST_MASK_LO]),
    .ev      (ev),
    .ie      (st_ie),
    .um      (st_um),
    .mask    (st_mask)
  );

  sysctl_cause #(.NIRQ(NIRQ)) u_cause (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_ca),
    .wd_code   (acc_wdata[CA_CODE_HI:CA_CODE_LO]),
    .trap_code (trap_code),
    .irq_lines (irq_lines),
    .ev        (ev),
    .pend      (ca_pend),
    .code      (ca_code)
  );

  sysctl_epc #(.XLEN(XLEN)) u_epc (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_epc),
    .wd      (acc_wdata),
    .capture (take_exc),
    .pc_in   (pc_in),
    .epc     (epc_q)
  );

  always_comb begin
    rd_status = '0;
    rd_status[ST_IE] = st_ie;
    rd_status[ST_UM] = st_um;
    rd_status[ST_MASK_HI:ST_MASK_LO] = st_mask;
    rd_cause = '0;
    rd_cause[CA_CODE_HI:CA_CODE_LO] = ca_code;
    rd_cause[CA_PEND_HI:CA_PEND_LO] = ca_pend;
    case (acc_addr)
      REG_STATUS: rd_mux = rd_status;
      REG_CAUSE:  rd_mux = rd_cause;
      REG_EPC:    rd_mux = epc_q;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_rdata      <= '0;
      redirect_valid <= 1'b0;
      redirect_pc    <= '0;
    end else begin
      acc_rdata <= rd_mux;
      case (ev)
        EV_TRAP, EV_IRQ: begin
          redirect_valid <= 1'b1;
          redirect_pc    <= VECTOR_ADDR;
        end
        EV_ERET: begin
          redirect_valid <= 1'b1;
          redirect_pc    <= epc_q;
        end
        default: redirect_valid <= 1'b0;
      endcase
    end
  end

  assign kernel_mode = ~st_um;
endmodule

// File: rtl/sysctl_checker.sv
module sysctl_checker #(
  parameter int              XLEN        = 32,
  parameter logic [XLEN-1:0] VECTOR_ADDR = 32'h8000_0080
) (
  input logic            clk,
  input logic            rst,
  input logic            trap_req,
  input logic [4:0]      trap_code,
  input logic [XLEN-1:0] pc_in,
  input logic [5:0]      irq_lines,
  input logic            eret_req,
  input logic            redirect_valid,
  input logic [XLEN-1:0] redirect_pc,
  input logic            kernel_mode,
  input logic            ie,
  input logic            um,
  input logic [5:0]      en_mask,
  input logic [5:0]      pend,
  input logic [4:0]      code,
  input logic [XLEN-1:0] epc
);
  logic irq_ok;
  assign irq_ok = ie && um && ((pend & en_mask) != 6'd0);

  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (kernel_mode && !redirect_valid && epc == '0 && code == 5'd0));

  assert_pend_follow_R4: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (pend == $past(irq_lines)));

  assert_trap_take_R5: assert property (@(posedge clk) disable iff (rst)
    trap_req |=> (redirect_valid && redirect_pc == VECTOR_ADDR && kernel_mode
                  && epc == $past(pc_in) && code == $past(trap_code)));

  assert_irq_take_R6: assert property (@(posedge clk) disable iff (rst)
    (!trap_req && irq_ok) |=> (redirect_valid && redirect_pc == VECTOR_ADDR
                               && kernel_mode && code == 5'd0 && epc == $past(pc_in)));

  assert_irq_blocked_R7: assert property (@(posedge clk) disable iff (rst)
    (!trap_req && !eret_req && !irq_ok) |=> !redirect_valid);

  assert_eret_R9: assert property (@(posedge clk) disable iff (rst)
    (eret_req && !trap_req && !irq_ok) |=> (redirect_valid && !kernel_mode
                                            && redirect_pc == $past(epc)));
endmodule

bind sysctl_cop sysctl_checker #(.XLEN(XLEN), .VECTOR_ADDR(VECTOR_ADDR)) i_chk (
  .clk            (clk),
  .rst            (rst),
  .trap_req       (trap_req),
  .trap_code      (trap_code),
  .pc_in          (pc_in),
  .irq_lines      (irq_lines),
  .eret_req       (eret_req),
  .redirect_valid (redirect_valid),
  .redirect_pc    (redirect_pc),
  .kernel_mode    (kernel_mode),
  .ie             (st_ie),
  .um             (st_um),
  .en_mask        (irq_mask),
  .pend           (ca_pend),
  .code           (ca_code),
  .epc            (epc_q)
);

// File: tb/test_sysctl_cop.sv
module test_sysctl_cop;
  localparam logic [31:0] VEC = 32'h8000_0080;

  logic        clk = 1'b0;
  logic        rst;
  logic        trap_req;
  logic [4:0]  trap_code;
  logic [31:0] pc_in;
  logic [5:0]  irq_lines;
  logic        eret_req;
  logic        acc_wr;
  logic [4:0]  acc_addr;
  logic [31:0] acc_wdata;
  logic [31:0] acc_rdata;
  logic        redirect_valid;
  logic [31:0] redirect_pc;
  logic        kernel_mode;

  always #10 clk = ~clk;

  sysctl_cop i_sysctl_cop (
    .clk(clk), .rst(rst), .trap_req(trap_req), .trap_code(trap_code),
    .pc_in(pc_in), .irq_lines(irq_lines), .eret_req(eret_req),
    .acc_wr(acc_wr), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
    .acc_rdata(acc_rdata), .redirect_valid(redirect_valid),
    .redirect_pc(redirect_pc), .kernel_mode(kernel_mode)
  );

  int n_cmp = 0;
  int n_bad = 0;
  string cur_tag = "R1";

  // Reference state built from the requirements
  logic        m_ie, m_um;
  logic [7:0]  m_mask;
  logic [5:0]  m_pend;
  logic [4:0]  m_code;
  logic [31:0] m_epc, m_rpc, m_rd;
  logic        m_rv;

  function automatic logic [31:0] f_read(input logic [4:0] a);
    case (a)
      5'd12:   return {16'h0, m_mask, 6'b0, m_um, m_ie};
      5'd13:   return {16'h0, m_pend, 3'b0, m_code, 2'b0};
      5'd14:   return m_epc;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic f_irq_ok();
    return m_ie && m_um && ((m_pend & m_mask[7:2]) != 6'd0);
  endfunction

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", cur_tag, what, act, exp, $time);
    end
  endtask

  task automatic model_step();
    logic [31:0] rd, old_epc;
    logic        irq_ok;
    if (rst) begin
      m_ie = 0; m_um = 0; m_mask = 0; m_pend = 0; m_code = 0;
      m_epc = 0; m_rv = 0; m_rpc = 0; m_rd = 0;
    end else begin
      rd      = f_read(acc_addr);
      irq_ok  = f_irq_ok();
      old_epc = m_epc;
      if (acc_wr && acc_addr == 5'd12) begin
        m_ie = acc_wdata[0]; m_um = acc_wdata[1]; m_mask = acc_wdata[15:8];
      end
      if (acc_wr && acc_addr == 5'd13) m_code = acc_wdata[6:2];
      if (acc_wr && acc_addr == 5'd14) m_epc = acc_wdata;
      if (trap_req) begin
        m_epc = pc_in; m_code = trap_code; m_um = 0; m_rv = 1; m_rpc = VEC;
      end else if (irq_ok) begin
        m_epc = pc_in; m_code = 5'd0; m_um = 0; m_rv = 1; m_rpc = VEC;
      end else if (eret_req) begin
        m_um = 1; m_rv = 1; m_rpc = old_epc;
      end else begin
        m_rv = 0;
      end
      m_pend = irq_lines;
      m_rd   = rd;
    end
  endtask

  // Apply current inputs for one rising edge, then compare at the falling edge.
  task automatic tick();
    model_step();
    @(negedge clk);
    check("redirect_valid", {31'b0, redirect_valid}, {31'b0, m_rv});
    check("redirect_pc", redirect_pc, m_rpc);
    check("kernel_mode", {31'b0, kernel_mode}, {31'b0, ~m_um});
    check("acc_rdata", acc_rdata, m_rd);
  endtask

  task automatic idle();
    trap_req = 0; eret_req = 0; acc_wr = 0; acc_wdata = 0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    acc_wr = 1; acc_addr = a; acc_wdata = d; tick(); acc_wr = 0;
  endtask

  task automatic rd(input logic [4:0] a);
    acc_addr = a; tick();
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    void'($urandom(32'd2024));
    rst = 1; trap_req = 0; trap_code = 0; pc_in = 0; irq_lines = 0;
    eret_req = 0; acc_wr = 0; acc_addr = 0; acc_wdata = 0;

    // R1: reset values on outputs and registers
    cur_tag = "R1";
    tick(); tick();
    rst = 0;
    rd(5'd12); rd(5'd13); rd(5'd14); rd(5'd12);

    // R2: unmapped numbers read 0 and ignore writes
    cur_tag = "R2";
    wr(5'd5, 32'hFFFF_FFFF); rd(5'd5); rd(5'd12); rd(5'd31); rd(5'd14);

    // R3: Status writable fields only
    cur_tag = "R3";
    wr(5'd12, 32'hFFFF_FFFF); rd(5'd12); rd(5'd12);
    wr(5'd12, 32'h0000_0000); rd(5'd12); rd(5'd12);

    // R4: Cause code writable, pending follows lines
    cur_tag = "R4";
    wr(5'd13, 32'hFFFF_FFFF); rd(5'd13); rd(5'd13);
    irq_lines = 6'b101010; rd(5'd13); rd(5'd13);
    irq_lines = 6'b010101; rd(5'd13); rd(5'd13);
    irq_lines = 0; rd(5'd13); rd(5'd13);

    // R7: enable off / kernel mode / masked -> no interrupt
    cur_tag = "R7";
    wr(5'd12, 32'h0000_FC01);            // enabled, kernel mode
    irq_lines = 6'b111111; tick(); tick(); tick();
    wr(5'd12, 32'h0000_FC02);            // user mode, enable off
    tick(); tick();
    wr(5'd12, 32'h0000_0303);            // user, enabled, lines masked
    tick(); tick();
    irq_lines = 0; tick();

    // R6: interrupt taken, code 0, EPC captured
    cur_tag = "R6";
    wr(5'd12, 32'h0000_0403);            // unmask line 0
    pc_in = 32'h0000_4010;
    irq_lines = 6'b000001; tick(); tick();
    irq_lines = 0; tick();
    rd(5'd14); rd(5'd13); rd(5'd13);

    // R9: return adds nothing, resumes at EPC, user mode
    cur_tag = "R9";
    wr(5'd14, 32'h0000_4014);
    eret_req = 1; tick(); eret_req = 0; tick();

    // R5: overflow trap
    cur_tag = "R5";
    pc_in = 32'h0000_5000; trap_code = 5'd12;
    trap_req = 1; tick(); trap_req = 0;
    rd(5'd14); rd(5'd13); rd(5'd13);

    // R8: trap and takeable interrupt together
    cur_tag = "R8";
    wr(5'd12, 32'h0000_FC03);
    irq_lines = 6'b000100; tick();
    pc_in = 32'h0000_6000; trap_code = 5'd10;
    trap_req = 1; tick(); trap_req = 0;
    irq_lines = 0; rd(5'd13); rd(5'd13);

    // R10: exception beats write to EPC and to Status mode, and beats return
    cur_tag = "R10";
    pc_in = 32'h0000_7000; trap_code = 5'd4;
    trap_req = 1; wr(5'd14, 32'hDEAD_BEE0); trap_req = 0;
    rd(5'd14); rd(5'd14);
    trap_req = 1; wr(5'd12, 32'h0000_0003); trap_req = 0;
    rd(5'd12); rd(5'd12);
    trap_req = 1; eret_req = 1; tick(); idle(); tick();

    // R11: quiet cycles hold redirect_pc
    cur_tag = "R11";
    tick(); tick();

    // Seeded random phase
    for (int i = 0; i < 3000; i++) begin
      trap_req  = ($urandom_range(0, 9) == 0);
      trap_code = 5'($urandom);
      eret_req  = ($urandom_range(0, 7) == 0);
      pc_in     = $urandom & 32'hFFFF_FFFC;
      irq_lines = ($urandom_range(0, 3) == 0) ? 6'($urandom) : 6'd0;
      acc_wr    = ($urandom_range(0, 3) == 0);
      acc_addr  = ($urandom_range(0, 3) == 0) ? 5'($urandom) : 5'(12 + $urandom_range(0, 2));
      acc_wdata = $urandom;
      if (trap_req)          cur_tag = "R5";
      else if (f_irq_ok())   cur_tag = "R6";
      else if (eret_req)     cur_tag = "R9";
      else if (acc_wr)       cur_tag = "R2";
      else                   cur_tag = "R11";
      tick();
    end
    idle();
    summary();
  end
endmodule